// File: doc/BRIEF.md
# One-Wire Search Branch Step

This block carries out a single branch decision of the one-wire ROM search. On a start command it asks an external bit-slot engine for two read slots: the first returns the id bit that the devices on the bus drive for the current address position, and the second returns that bit's complement. From the pair it decides which way the search goes. It then asks the engine for one write slot that sends the chosen direction back onto the bus, so that devices on the other branch drop out.

When both reads return 1, no device is responding and the search has to restart. In that case the block reports an error and sends no write slot. When both reads return 0, devices exist on both branches and the block follows the preferred direction given with the start command. When exactly one read returns 1, only one branch exists and the direction is forced to the id bit. The enclosing search controller keeps track of the discrepancy position and the address, and it drives this block once per address bit.

Top module: `owb_search_step`

## Requirements
- R1: `start` is accepted only while `busy` is low. `pref_dir` is captured in the cycle `start` is accepted. Later changes of `pref_dir`, and `start` pulses while `busy` is high, do not affect the step in progress.
- R2: After acceptance the block requests exactly two read slots (`slot_req`=1, `slot_write`=0). The first is for the id bit and the second for the complement bit. The first request is present in the cycle after acceptance.
- R3: `stat` bit 0 holds the id bit read, bit 1 holds the complement bit read, and bit 2 holds the direction taken.
- R4: When both reads return 1, `stat` is 3'b011 and no write slot is requested in that step.
- R5: When both reads return 0, the direction is the captured preferred direction, and `stat` is 3'b100 for direction 1 or 3'b000 for direction 0.
- R6: When exactly one read returns 1, the direction equals the id bit, and `stat` is 3'b101 for id 1 or 3'b010 for id 0.
- R7: In every step that is not an error, exactly one write slot is requested (`slot_write`=1) after the two reads. `slot_wdata` carries the direction and stays stable until `slot_done`.
- R8: `stat_valid` is high for exactly one cycle per step. `stat` keeps its value after the pulse until the next step decides.
- R9: A `slot_done` pulse while no slot is requested is ignored: it produces no status and no slot request.
- R10: While reset is held, `busy`, `slot_req` and `stat_valid` are 0 and `stat` is 3'b000.
- R11: A `start` that is present in the same cycle as `stat_valid` is ignored. In the following cycle `busy` and `slot_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begin one branch step (sampled only when idle) |
| pref_dir | input | 1 | Direction to take when both branches are present |
| busy | output | 1 | High from acceptance until the status pulse has passed |
| slot_req | output | 1 | Request to the bit-slot engine, held until `slot_done` |
| slot_write | output | 1 | 1 = write slot, 0 = read slot |
| slot_wdata | output | 1 | Bit to send in a write slot |
| slot_done | input | 1 | One-cycle completion pulse from the slot engine |
| slot_rdata | input | 1 | Bus level sampled by a read slot, valid with `slot_done` |
| stat_valid | output | 1 | One-cycle strobe marking a new status |
| stat | output | 3 | {direction, complement bit, id bit} |

## Verification
Two things can coincide here. The first is the status report of one step together with a new start command. The bench raises `start` in exactly the cycle where `stat_valid` is seen, then checks that the next cycle shows neither `busy` nor a slot request. The second is a stray completion from the slot engine arriving while the block is idle. The bench injects `slot_done` with no request outstanding, then confirms that no status appears and that the next real step still produces its expected status from the scoreboard queue.

// File: rtl/owb_pkg.sv
package owb_pkg;
  localparam int STAT_W   = 3;
  localparam int STAT_ID  = 0;
  localparam int STAT_CMP = 1;
  localparam int STAT_DIR = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ID,
    ST_RD_CMP,
    ST_DECIDE,
    ST_WR,
    ST_REPORT
  } owb_state_e;

  function automatic logic [STAT_W-1:0] pack_stat(input logic id_b, input logic cmp_b,
                                                  input logic dir_b);
    logic [STAT_W-1:0] s;
    s = '0;
    s[STAT_ID]  = id_b;
    s[STAT_CMP] = cmp_b;
    s[STAT_DIR] = dir_b;
    return s;
  endfunction
endpackage

// File: rtl/owb_seq_fsm.sv
module owb_seq_fsm
  import owb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       slot_done,
  input  logic       err,
  output owb_state_e state,
  output logic       accept,
  output logic       cap_id_en,
  output logic       cap_cmp_en,
  output logic       stat_en
);
  owb_state_e state_nxt;

  always_comb begin
    state_nxt = state;
    case (state)
      ST_IDLE:   if (start)     state_nxt = ST_RD_ID;
      ST_RD_ID:  if (slot_done) state_nxt = ST_RD_CMP;
      ST_RD_CMP: if (slot_done) state_nxt = ST_DECIDE;
      ST_DECIDE: state_nxt = err ? ST_REPORT : ST_WR;
      ST_WR:     if (slot_done) state_nxt = ST_REPORT;
      ST_REPORT: state_nxt = ST_IDLE;
      default:   state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end

  assign accept     = (state == ST_IDLE) && start;
  assign cap_id_en  = (state == ST_RD_ID) && slot_done;
  assign cap_cmp_en = (state == ST_RD_CMP) && slot_done;
  assign stat_en    = (state == ST_DECIDE);
endmodule

// File: rtl/owb_bit_capture.sv
module owb_bit_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic pref_in,
  input  logic cap_id_en,
  input  logic cap_cmp_en,
  input  logic rdata,
  output logic id_q,
  output logic cmp_q,
  output logic pref_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q   <= 1'b0;
      cmp_q  <= 1'b0;
      pref_q <= 1'b0;
    end else begin
      if (accept)     pref_q <= pref_in;
      if (cap_id_en)  id_q   <= rdata;
      if (cap_cmp_en) cmp_q  <= rdata;
    end
  end
endmodule

// File: rtl/owb_branch_decide.sv
module owb_branch_decide
  import owb_pkg::*;
(
  input  logic              id_b,
  input  logic              cmp_b,
  input  logic              pref_b,
  output logic              err,
  output logic [STAT_W-1:0] stat_nxt
);
  logic dir_b;

  always_comb begin
    err   = id_b & cmp_b;
    dir_b = 1'b0;
    if (!id_b && !cmp_b) dir_b = pref_b;
    else if (!err)       dir_b = id_b;
    stat_nxt = pack_stat(id_b, cmp_b, dir_b);
  end
endmodule

// File: rtl/owb_search_step.sv
module owb_search_step
  import owb_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pref_dir,
  output logic              busy,
  output logic              slot_req,
  output logic              slot_write,
  output logic              slot_wdata,
  input  logic              slot_done,
  input  logic              slot_rdata,
  output logic              stat_valid,
  output logic [STAT_W-1:0] stat
);
  logic [RST_STAGES-1:0] rst_sync;
  logic                  rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[RST_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync[RST_STAGES-1];

  owb_state_e        state;
  logic              accept, cap_id_en, cap_cmp_en, stat_en, err;
  logic              id_q, cmp_q, pref_q;
  logic [STAT_W-1:0] stat_nxt, stat_q;

  owb_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .start      (start),
    .slot_done  (slot_done),
    .err        (err),
    .state      (state),
    .accept     (accept),
    .cap_id_en  (cap_id_en),
    .cap_cmp_en (cap_cmp_en),
    .stat_en    (stat_en)
  );

  owb_bit_capture u_cap (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .accept     (accept),
    .pref_in    (pref_dir),
    .cap_id_en  (cap_id_en),
    .cap_cmp_en (cap_cmp_en),
    .rdata      (slot_rdata),
    .id_q       (id_q),
    .cmp_q      (cmp_q),
    .pref_q     (pref_q)
  );

  owb_branch_decide u_dec (
    .id_b     (id_q),
    .cmp_b    (cmp_q),
    .pref_b   (pref_q),
    .err      (err),
    .stat_nxt (stat_nxt)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  stat_q <= '0;
    else if (stat_en) stat_q <= stat_nxt;
  end

  assign busy       = (state != ST_IDLE);
  assign slot_req   = (state == ST_RD_ID) || (state == ST_RD_CMP) || (state == ST_WR);
  assign slot_write = (state == ST_WR);
  assign slot_wdata = (state == ST_WR) ? stat_q[STAT_DIR] : 1'b0;
  assign stat_valid = (state == ST_REPORT);
  assign stat       = stat_q;
endmodule

// File: rtl/owb_search_step_chk.sv
module owb_search_step_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       slot_req,
  input logic       slot_write,
  input logic       slot_wdata,
  input logic       slot_done,
  input logic       stat_valid,
  input logic [2:0] stat
);
  logic [1:0] wr_cnt;
  logic       wr_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cnt <= 2'd0;
      wr_bit <= 1'b0;
    end else if (start && !busy) begin
      wr_cnt <= 2'd0;
    end else if (slot_req && slot_write && slot_done) begin
      if (wr_cnt != 2'd3) wr_cnt <= wr_cnt + 2'd1;
      wr_bit <= slot_wdata;
    end
  end

  // R2: first request after acceptance is a read slot
  p_first_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (slot_req && !slot_write));

  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |=> !stat_valid);

  p_err_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat[1:0] == 2'b11) |-> (wr_cnt == 2'd0));

  p_write_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat[1:0] != 2'b11) |-> (wr_cnt == 2'd1 && wr_bit == stat[2]));

  p_force_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && (stat[0] ^ stat[1])) |-> (stat[2] == stat[0]));

  p_wdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && slot_write && !slot_done) |=> (slot_req && slot_write && $stable(slot_wdata)));
endmodule

bind owb_search_step owb_search_step_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .start      (start),
  .busy       (busy),
  .slot_req   (slot_req),
  .slot_write (slot_write),
  .slot_wdata (slot_wdata),
  .slot_done  (slot_done),
  .stat_valid (stat_valid),
  .stat       (stat)
);

// File: tb/tb_owb_search_step.sv
module tb_owb_search_step;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk, rst_n, start, pref_dir, busy, slot_req, slot_write, slot_wdata;
  logic       slot_done, slot_rdata, stat_valid;
  logic [2:0] stat;

  owb_search_step dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pref_dir(pref_dir), .busy(busy),
    .slot_req(slot_req), .slot_write(slot_write), .slot_wdata(slot_wdata),
    .slot_done(slot_done), .slot_rdata(slot_rdata), .stat_valid(stat_valid), .stat(stat)
  );

  int checks = 0, failures = 0;
  logic [2:0] exp_q[$];
  logic cur_id, cur_cmp, inject_req, last_wbit;
  int cur_lat, lat_cnt, n_rd, n_wr, n_slot, n_valid;
  logic kinds [0:7];
  bit finished = 0;

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] model(input logic id, input logic cmp, input logic pref);
    if (id && cmp) return 3'b011;
    if (!id && !cmp) return {pref, 2'b00};
    return {id, cmp, id};
  endfunction

  // slot engine model
  initial begin
    slot_done = 0; slot_rdata = 0; lat_cnt = 0; inject_req = 0;
    n_rd = 0; n_wr = 0; n_slot = 0; last_wbit = 0; cur_lat = 1;
    forever begin
      @(negedge clk);
      if (slot_done) begin
        slot_done = 0; lat_cnt = 0;
      end else if (inject_req && !slot_req) begin
        slot_done = 1; inject_req = 0;
      end else if (slot_req) begin
        lat_cnt++;
        if (lat_cnt >= cur_lat) begin
          slot_done = 1;
          if (slot_write) begin
            n_wr++; last_wbit = slot_wdata; kinds[n_slot % 8] = 1'b1;
          end else begin
            slot_rdata = (n_rd == 0) ? cur_id : cur_cmp;
            n_rd++; kinds[n_slot % 8] = 1'b0;
          end
          n_slot++;
        end
      end
    end
  end

  // scoreboard monitor
  initial begin
    logic prev_v;
    logic [2:0] held, e;
    prev_v = 0; held = 0; n_valid = 0;
    forever begin
      @(negedge clk);
      if (rst_n && prev_v) begin
        chk(!stat_valid, "R8 pulse width", stat_valid, 0);
        chk(stat == held, "R8 stat held", stat, held);
      end
      if (rst_n && stat_valid) begin
        n_valid++;
        if (exp_q.size() == 0) chk(0, "R9 unexpected status", stat, 0);
        else begin
          e = exp_q.pop_front();
          if (e[1:0] == 2'b11)      chk(stat == e, "R4 error status", stat, e);
          else if (e[1:0] == 2'b00) chk(stat == e, "R5 preferred dir", stat, e);
          else                      chk(stat == e, "R6 forced dir", stat, e);
          chk(stat[0] == e[0] && stat[1] == e[1], "R3 bit fields", stat, e);
        end
        held = stat;
      end
      prev_v = stat_valid;
    end
  end

  // mode: 0 normal, 1 restart while busy, 2 start during status cycle
  task automatic run_step(input logic id, input logic cmp, input logic pref,
                          input int lat, input int mode);
    logic [2:0] e;
    e = model(id, cmp, pref);
    exp_q.push_back(e);
    cur_id = id; cur_cmp = cmp; cur_lat = lat; n_rd = 0; n_wr = 0; n_slot = 0;
    @(negedge clk); start = 1; pref_dir = pref;
    @(negedge clk); start = 0; pref_dir = ~pref;
    chk(slot_req && !slot_write, "R2 first read request", {slot_req, slot_write}, 2);
    if (mode == 1) begin
      start = 1; // R1: ignored while busy
      @(negedge clk); start = 0;
    end
    while (!stat_valid) @(negedge clk);
    if (mode == 2) begin
      start = 1; // R11: coincides with stat_valid
      @(negedge clk); start = 0;
      chk(!slot_req && !busy, "R11 start in report cycle", {slot_req, busy}, 0);
    end else begin
      @(negedge clk);
      chk(!busy, "R1 idle after step", busy, 0);
    end
    chk(n_rd == 2 && kinds[0] == 0 && kinds[1] == 0, "R2 two reads first", n_rd, 2);
    if (e[1:0] == 2'b11) chk(n_wr == 0, "R4 no write on error", n_wr, 0);
    else begin
      chk(n_wr == 1 && kinds[2] == 1, "R7 one write slot", n_wr, 1);
      chk(last_wbit == e[2], "R7 write carries dir", last_wbit, e[2]);
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!finished && cyc < WATCHDOG) begin @(posedge clk); cyc++; end
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v0;
    rst_n = 0; start = 0; pref_dir = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !slot_req && !stat_valid && stat == 3'b000, "R10 reset state",
        {busy, slot_req, stat_valid, stat}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    run_step(0, 0, 1, 1, 0);  // R5 -> 100
    run_step(0, 0, 0, 2, 0);  // R5 -> 000
    run_step(1, 0, 0, 1, 0);  // R6 -> 101
    run_step(0, 1, 1, 3, 0);  // R6 -> 010
    run_step(1, 1, 1, 1, 0);  // R4 -> 011
    run_step(1, 1, 0, 2, 2);  // R4 with R11
    run_step(0, 0, 1, 2, 1);  // R1: pref captured, restart ignored
    run_step(1, 0, 1, 1, 2);  // R6 with R11

    // R9: stray completion while idle
    v0 = n_valid;
    inject_req = 1;
    repeat (4) @(negedge clk);
    chk(n_valid == v0 && !slot_req && !busy, "R9 stray done ignored", n_valid - v0, 0);
    run_step(0, 1, 0, 1, 0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all statuses seen", exp_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule